// File: doc/BRIEF.md
# Saturating Arithmetic Unit

This unit is a combinational 32-bit arithmetic datapath with one registered overflow flag that stays set. Each cycle an opcode chooses one of ten operations: signed add or subtract that clamps, signed add that wraps and only raises the flag, signed doubling that clamps, unsigned add or subtract that clamps, clamping to a signed or unsigned range set by a 5-bit bit position, and two forms that clamp the two 16-bit halves of a word independently.

The result follows the inputs within the same cycle. The flag is the only state. It can only go high on a cycle with `valid_i` asserted and an operation that clamped or overflowed. It only goes low when `clr_i` is asserted. A surrounding pipeline drives one operation per cycle, reads `result_o` directly, and reads or clears the flag at its own points.

Top module: `sat_alu`

## Requirements
- R1: Opcode 0 is a signed add. If the true sum does not fit in 32 bits, the result is 0x7FFFFFFF when a is non-negative and 0x80000000 when a is negative, and a saturation event occurs. Otherwise the result is a+b.
- R2: Opcode 1 is a signed subtract a-b. It clamps to the same limits as R1, chosen by the sign of a, and raises a saturation event on overflow.
- R3: Opcode 2 returns the wrapped sum a+b modulo 2^32. It raises a saturation event when the signed sum overflows.
- R4: Opcode 3 doubles signed a. A value of 0x40000000 or more gives 0x7FFFFFFF. A value of 0xC0000000 or less gives 0x80000000. Either case raises a saturation event, and this includes a = 0xC0000000 exactly. Any other value gives a shifted left by one.
- R5: Opcode 4 is an unsigned add. When the sum exceeds 0xFFFFFFFF the result is 0xFFFFFFFF and a saturation event occurs.
- R6: Opcode 5 is an unsigned subtract. When b exceeds a the result is 0 and a saturation event occurs.
- R7: Opcode 6 clamps signed a to the range [-2^n, 2^n-1], where n is pos_i (0 to 31), and raises an event when a is outside that range. With n = 0 the range is [-1, 0].
- R8: Opcode 7 clamps signed a to the range [0, 2^n-1] and raises an event when a is outside that range.
- R9: Opcode 8 applies R7 separately to a[15:0] and to a[31:16], each sign-extended. The low 16 bits of each result go back into the same half. An event in either half counts.
- R10: Opcode 9 applies R8 separately to each sign-extended half in the same way as R9.
- R11: sat_flag_o is 0 after reset. It goes to 1 on the clock edge after a cycle with valid_i=1 and a saturation event. Cycles with valid_i=0 never change it.
- R12: clr_i=1 clears sat_flag_o at the next edge. When the same cycle also has a valid saturation event, the flag ends at 1.
- R13: Opcodes 10 to 15 give a result of 0 and never raise a saturation event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation valid; allows the flag to be set |
| clr_i | input | 1 | Clears the sticky flag |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| pos_i | input | 5 | Saturation bit position n |
| result_o | output | 32 | Combinational result |
| sat_flag_o | output | 1 | Sticky saturation flag |

## Verification
A saturation event and a flag clear can happen in the same cycle, and both act on the one flag bit. The bench provokes this in two ways. Directed steps assert clr_i together with an operation that clamps, and also together with one that does not. Long random runs toggle clr_i and valid_i independently of the operands. After each such cycle the flag is read at the port and judged against a model in which a valid event wins over the clear. A valid_i=0 cycle with an operand that would clamp confirms that no event is taken without a valid strobe.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic [3:0] {
        OP_SADD   = 4'd0,
        OP_SSUB   = 4'd1,
        OP_ADDF   = 4'd2,
        OP_DBL    = 4'd3,
        OP_UADD   = 4'd4,
        OP_USUB   = 4'd5,
        OP_SSATN  = 4'd6,
        OP_USATN  = 4'd7,
        OP_SSAT16 = 4'd8,
        OP_USAT16 = 4'd9
    } sat_op_e;

    // Decoded control for the datapath
    typedef struct packed {
        logic legal;
        logic is_sub;
        logic is_unsigned;
        logic clamp_en;
        logic is_dbl;
        logic is_satpos;
        logic sat_unsigned;
        logic dual;
    } sat_ctl_t;

    function automatic sat_ctl_t sat_decode(input logic [3:0] op);
        sat_ctl_t c;
        c = '0;
        c.legal = 1'b1;
        case (op)
            OP_SADD:   c.clamp_en = 1'b1;
            OP_SSUB:   begin c.clamp_en = 1'b1; c.is_sub = 1'b1; end
            OP_ADDF:   c.clamp_en = 1'b0;
            OP_DBL:    c.is_dbl = 1'b1;
            OP_UADD:   c.is_unsigned = 1'b1;
            OP_USUB:   begin c.is_unsigned = 1'b1; c.is_sub = 1'b1; end
            OP_SSATN:  c.is_satpos = 1'b1;
            OP_USATN:  begin c.is_satpos = 1'b1; c.sat_unsigned = 1'b1; end
            OP_SSAT16: begin c.is_satpos = 1'b1; c.dual = 1'b1; end
            OP_USAT16: begin c.is_satpos = 1'b1; c.dual = 1'b1; c.sat_unsigned = 1'b1; end
            default:   c.legal = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
    import sat_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  sat_ctl_t            ctl_i,
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    output logic [DATA_W-1:0]   res_o,
    output logic                hit_o
);
    localparam int unsigned MSB = DATA_W - 1;
    localparam logic [DATA_W-1:0] S_MAX = {1'b0, {MSB{1'b1}}};
    localparam logic [DATA_W-1:0] S_MIN = {1'b1, {MSB{1'b0}}};
    localparam logic [DATA_W-1:0] U_MAX = '1;

    logic [DATA_W:0]   wide;
    logic [DATA_W-1:0] sum;
    logic              carry;
    logic              s_ovf;
    logic              dbl_hi;
    logic              dbl_lo;

    always_comb begin
        if (ctl_i.is_sub) wide = {1'b0, a_i} - {1'b0, b_i};
        else              wide = {1'b0, a_i} + {1'b0, b_i};
    end

    assign sum   = wide[MSB:0];
    assign carry = wide[DATA_W];

    always_comb begin
        if (ctl_i.is_sub)
            s_ovf = (sum[MSB] ^ a_i[MSB]) & (a_i[MSB] ^ b_i[MSB]);
        else
            s_ovf = (sum[MSB] ^ a_i[MSB]) & ~(a_i[MSB] ^ b_i[MSB]);
    end

    // doubling limits: a >= 2^(W-2) or a <= -2^(W-2)
    assign dbl_hi = ~a_i[MSB] & a_i[MSB-1];
    assign dbl_lo = a_i[MSB] & (~a_i[MSB-1] | (a_i[MSB-2:0] == '0));

    always_comb begin
        res_o = sum;
        hit_o = 1'b0;
        if (ctl_i.is_dbl) begin
            if (dbl_hi) begin
                res_o = S_MAX;
                hit_o = 1'b1;
            end else if (dbl_lo) begin
                res_o = S_MIN;
                hit_o = 1'b1;
            end else begin
                res_o = {a_i[MSB-1:0], 1'b0};
            end
        end else if (ctl_i.is_unsigned) begin
            if (carry) begin
                hit_o = 1'b1;
                res_o = ctl_i.is_sub ? '0 : U_MAX;
            end
        end else if (s_ovf) begin
            hit_o = 1'b1;
            if (ctl_i.clamp_en) res_o = a_i[MSB] ? S_MIN : S_MAX;
        end
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned POS_W  = 5
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic              uns_i,
    output logic [DATA_W-1:0] res_o,
    output logic              hit_o
);
    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] top;
    logic              top_pos;
    logic              top_neg;

    assign mask    = (DATA_W'(1) << pos_i) - DATA_W'(1);
    assign top     = DATA_W'($signed(val_i) >>> pos_i);
    assign top_pos = ~top[MSB] & (|top);
    assign top_neg = top[MSB] & ~(&top);

    always_comb begin
        res_o = val_i;
        hit_o = 1'b0;
        if (uns_i) begin
            if (val_i[MSB]) begin
                res_o = '0;
                hit_o = 1'b1;
            end else if (val_i > mask) begin
                res_o = mask;
                hit_o = 1'b1;
            end
        end else begin
            if (top_pos) begin
                res_o = mask;
                hit_o = 1'b1;
            end else if (top_neg) begin
                res_o = ~mask;
                hit_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_flag.sv
module sat_flag (
    input  logic clk_i,
    input  logic rst_i,
    input  logic valid_i,
    input  logic hit_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)                  flag_o <= 1'b0;
        else if (valid_i && hit_i)  flag_o <= 1'b1;
        else if (clr_i)             flag_o <= 1'b0;
    end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANES  = 2
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       valid_i,
    input  logic                       clr_i,
    input  logic [3:0]                 op_i,
    input  logic [DATA_W-1:0]          a_i,
    input  logic [DATA_W-1:0]          b_i,
    input  logic [$clog2(DATA_W)-1:0]  pos_i,
    output logic [DATA_W-1:0]          result_o,
    output logic                       sat_flag_o
);
    localparam int unsigned POS_W  = $clog2(DATA_W);
    localparam int unsigned LANE_W = DATA_W / LANES;

    sat_ctl_t          ctl;
    logic [DATA_W-1:0] arith_res;
    logic              arith_hit;
    logic [DATA_W-1:0] full_res;
    logic              full_hit;
    logic [DATA_W-1:0] dual_res;
    logic [LANES-1:0]  lane_hit;
    logic              sat_hit;

    assign ctl = sat_decode(op_i);

    sat_addsub #(.DATA_W(DATA_W)) u_arith (
        .ctl_i (ctl),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (arith_res),
        .hit_o (arith_hit)
    );

    sat_clamp #(.DATA_W(DATA_W), .POS_W(POS_W)) u_full (
        .val_i (a_i),
        .pos_i (pos_i),
        .uns_i (ctl.sat_unsigned),
        .res_o (full_res),
        .hit_o (full_hit)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DATA_W-1:0] lane_in;
        logic [DATA_W-1:0] lane_out;
        assign lane_in = {{(DATA_W-LANE_W){a_i[g*LANE_W+LANE_W-1]}}, a_i[g*LANE_W +: LANE_W]};
        sat_clamp #(.DATA_W(DATA_W), .POS_W(POS_W)) u_lane (
            .val_i (lane_in),
            .pos_i (pos_i),
            .uns_i (ctl.sat_unsigned),
            .res_o (lane_out),
            .hit_o (lane_hit[g])
        );
        assign dual_res[g*LANE_W +: LANE_W] = lane_out[LANE_W-1:0];
    end

    always_comb begin
        result_o = '0;
        sat_hit  = 1'b0;
        if (ctl.legal) begin
            if (ctl.is_satpos) begin
                if (ctl.dual) begin
                    result_o = dual_res;
                    sat_hit  = |lane_hit;
                end else begin
                    result_o = full_res;
                    sat_hit  = full_hit;
                end
            end else begin
                result_o = arith_res;
                sat_hit  = arith_hit;
            end
        end
    end

    sat_flag u_flag (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .valid_i (valid_i),
        .hit_i   (sat_hit),
        .clr_i   (clr_i),
        .flag_o  (sat_flag_o)
    );
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk
    import sat_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              valid_i,
    input logic              clr_i,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [DATA_W-1:0] result_o,
    input logic              sat_flag_o,
    input logic              hit_i
);
    p_uadd_floor_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_UADD) |-> (result_o >= a_i));

    p_usub_ceiling_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_USUB) |-> (result_o <= a_i));

    p_wrap_sum_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_ADDF) |-> (result_o == a_i + b_i));

    p_unused_zero_r13: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i > 4'd9) |-> (result_o == '0 && !hit_i));

    p_flag_set_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && hit_i) |=> sat_flag_o);

    p_flag_idle_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (!valid_i && !clr_i) |=> $stable(sat_flag_o));

    p_flag_hold_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        (sat_flag_o && !clr_i) |=> sat_flag_o);

    p_flag_clear_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_i && !(valid_i && hit_i)) |=> !sat_flag_o);
endmodule

bind sat_alu sat_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .valid_i    (valid_i),
    .clr_i      (clr_i),
    .op_i       (op_i),
    .a_i        (a_i),
    .b_i        (b_i),
    .result_o   (result_o),
    .sat_flag_o (sat_flag_o),
    .hit_i      (sat_hit)
);

// File: tb/sim_sat_alu.sv
module sim_sat_alu;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid;
    logic        clr;
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  pos;
    logic [31:0] result;
    logic        flag;

    int checks = 0;
    int errors = 0;
    bit exp_flag = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sat_alu u0 (
        .clk_i(clk), .rst_i(rst), .valid_i(valid), .clr_i(clr),
        .op_i(op), .a_i(a), .b_i(b), .pos_i(pos),
        .result_o(result), .sat_flag_o(flag)
    );

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0: return "R1";   4'd1: return "R2";
            4'd2: return "R3";   4'd3: return "R4";
            4'd4: return "R5";   4'd5: return "R6";
            4'd6: return "R7";   4'd7: return "R8";
            4'd8: return "R9";   4'd9: return "R10";
            default: return "R13";
        endcase
    endfunction

    // clamp v into [lo, hi]
    function automatic longint clampv(input longint v, input longint lo,
                                      input longint hi, inout bit h);
        if (v > hi) begin h = 1; return hi; end
        if (v < lo) begin h = 1; return lo; end
        return v;
    endfunction

    function automatic longint lim_s_hi(input int n); return (longint'(1) << n) - 1; endfunction
    function automatic longint lim_s_lo(input int n); return -(longint'(1) << n); endfunction

    task automatic model(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                         input logic [4:0] n, output logic [31:0] r, output bit h);
        longint sx, sy, ux, uy, t, lo16, hi16;
        h  = 0;
        sx = longint'($signed(x)); sy = longint'($signed(y));
        ux = longint'(x); uy = longint'(y);
        case (o)
            4'd0: begin t = clampv(sx + sy, -(longint'(1) << 31), (longint'(1) << 31) - 1, h); r = t[31:0]; end
            4'd1: begin t = clampv(sx - sy, -(longint'(1) << 31), (longint'(1) << 31) - 1, h); r = t[31:0]; end
            4'd2: begin t = sx + sy; if (t > 64'sd2147483647 || t < -64'sd2147483648) h = 1; r = t[31:0]; end
            4'd3: begin
                if (sx >= (longint'(1) << 30))       begin h = 1; r = 32'h7FFF_FFFF; end
                else if (sx <= -(longint'(1) << 30)) begin h = 1; r = 32'h8000_0000; end
                else begin t = 2 * sx; r = t[31:0]; end
            end
            4'd4: begin t = clampv(ux + uy, 0, 64'hFFFF_FFFF, h); r = t[31:0]; end
            4'd5: begin t = clampv(ux - uy, 0, 64'hFFFF_FFFF, h); r = t[31:0]; end
            4'd6: begin t = clampv(sx, lim_s_lo(n), lim_s_hi(n), h); r = t[31:0]; end
            4'd7: begin t = clampv(sx, 0, lim_s_hi(n), h); r = t[31:0]; end
            4'd8, 4'd9: begin
                lo16 = longint'($signed(x[15:0]));
                hi16 = longint'($signed(x[31:16]));
                if (o == 4'd8) begin
                    lo16 = clampv(lo16, lim_s_lo(n), lim_s_hi(n), h);
                    hi16 = clampv(hi16, lim_s_lo(n), lim_s_hi(n), h);
                end else begin
                    lo16 = clampv(lo16, 0, lim_s_hi(n), h);
                    hi16 = clampv(hi16, 0, lim_s_hi(n), h);
                end
                r = {hi16[15:0], lo16[15:0]};
            end
            default: r = 32'h0;
        endcase
    endtask

    task automatic check_flag(input string why);
        checks++;
        if (flag !== exp_flag) begin
            errors++;
            $display("FAIL %s flag: got %0b expected %0b", why, flag, exp_flag);
        end
    endtask

    task automatic step(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                        input logic [4:0] n, input bit v, input bit c);
        logic [31:0] er;
        bit eh;
        @(negedge clk);
        check_flag("R11 R12");
        op = o; a = x; b = y; pos = n; valid = v; clr = c;
        #2;
        model(o, x, y, n, er, eh);
        checks++;
        if (result !== er) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h n=%0d: got %h expected %h",
                     tag_of(o), o, x, y, n, result, er);
        end
        if (v && eh) exp_flag = 1'b1;
        else if (c)  exp_flag = 1'b0;
    endtask

    initial begin
        rst = 1'b1; valid = 0; clr = 0; op = 0; a = 0; b = 0; pos = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_flag("R11 reset");

        // R1 signed add
        step(0, 32'h7FFF_FFFF, 32'h1, 0, 1, 0);
        step(0, 32'h0000_0005, 32'h3, 0, 1, 1);
        step(0, 32'h8000_0000, 32'hFFFF_FFFF, 0, 1, 1);
        // R2 signed subtract
        step(1, 32'h8000_0000, 32'h1, 0, 0, 1);
        step(1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 1, 0);
        step(1, 32'h0000_0010, 32'h20, 0, 1, 1);
        // R3 flag-only add
        step(2, 32'h7FFF_FFFF, 32'h1, 0, 1, 0);
        step(2, 32'h1234_0000, 32'h1, 0, 0, 1);
        // R4 doubling
        step(3, 32'h4000_0000, 0, 0, 1, 1);
        step(3, 32'h3FFF_FFFF, 0, 0, 1, 1);
        step(3, 32'hC000_0000, 0, 0, 1, 0);
        step(3, 32'hC000_0001, 0, 0, 1, 1);
        // R5, R6 unsigned
        step(4, 32'hFFFF_FFFF, 32'h2, 0, 1, 1);
        step(4, 32'h0000_0001, 32'h2, 0, 1, 1);
        step(5, 32'h0000_0001, 32'h2, 0, 1, 1);
        step(5, 32'h0000_0009, 32'h2, 0, 1, 1);
        // R7 signed position, including n = 0
        step(6, 32'h0000_0000, 0, 0, 1, 1);
        step(6, 32'hFFFF_FFFF, 0, 0, 1, 1);
        step(6, 32'h0000_0005, 0, 0, 1, 1);
        step(6, 32'hFFFF_FFFB, 0, 0, 1, 1);
        step(6, 32'd200, 0, 7, 1, 1);
        step(6, -32'sd200, 0, 7, 1, 1);
        step(6, 32'd100, 0, 7, 1, 1);
        // R8 unsigned position
        step(7, 32'd300, 0, 8, 1, 1);
        step(7, -32'sd3, 0, 8, 1, 1);
        step(7, 32'd255, 0, 8, 1, 1);
        step(7, 32'd1, 0, 0, 1, 1);
        // R9, R10 dual halves
        step(8, 32'h7FFF_8000, 0, 7, 1, 1);
        step(8, 32'h0010_FFF0, 0, 7, 1, 1);
        step(9, 32'hFFFF_0123, 0, 8, 1, 1);
        step(9, 32'h0050_0040, 0, 8, 1, 1);
        // R13 unused opcodes
        step(4'hA, 32'h7FFF_FFFF, 32'h1, 0, 1, 1);
        step(4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 31, 1, 0);
        // R11 no set without valid; R12 clear vs set same cycle
        step(0, 32'h7FFF_FFFF, 32'h1, 0, 0, 0);
        step(0, 32'h7FFF_FFFF, 32'h1, 0, 1, 1);
        step(0, 32'h1, 32'h1, 0, 1, 0);
        step(0, 32'h1, 32'h1, 0, 1, 1);
        step(0, 32'h1, 32'h1, 0, 0, 0);

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (($urandom % 4) == 0) ra = {ra[31], {3{ra[30]}}, ra[27:0]};
            step(4'($urandom % 12), ra, rb, 5'($urandom), 1'($urandom % 2), (($urandom % 5) == 0));
        end

        @(negedge clk);
        check_flag("R11 R12 final");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule